// File: doc/BRIEF.md
# Single-Channel DMA Engine with Bus-Exception Abort

The block is one DMA channel that moves operands over a synchronous bus. In dual-address mode each operand takes a read cycle from the source address, which fills a one-operand holding register. A write cycle to the destination address follows. In single-address mode each operand is a single bus cycle at the source address. During that cycle a peripheral acknowledge output tells the external device to supply or accept the data directly. A controller loads source, destination and count, then pulses a start strobe. The channel requests the bus, waits for the grant and then runs its cycles until the count is exhausted.

Most of the logic deals with exceptions. The synchronous reset aborts the channel in the same cycle it is seen. It drops the bus request and the pin drive enable, returns the channel to idle and clears status. A transfer-error input ends the current cycle. It sets a sticky error status bit, can raise a maskable interrupt, and discards any operand held internally. It also parks the channel in a halted state. From there the channel issues no bus cycle until the controller pulses a re-initialise strobe.

Top module: `dma_err_chan`

## Requirements
- R1: While `rst` is high, `bus_req`, `bus_cyc` and `hs_ack` are low in that same cycle. After reset the channel is idle, and `sts` and `irq` read 0.
- R2: In dual-address mode (`cfg_single`=0), a start with count N≥1 performs N operands. Operand i is a read at `cfg_src`+i followed by a write of the read data at `cfg_dst`+i. `sts` bit 0 (done) sets when the last write completes.
- R3: `bus_req` stays high from start acceptance until the channel returns to idle. No bus cycle begins unless `bus_grant` was high in the cycle before.
- R4: `bus_err` during a cycle ends that cycle, and `sts` bit 1 (error) reads 1 in the next cycle. When `bus_ack` and `bus_err` arrive together, the error takes effect.
- R5: In the cycle after a transfer error, `bus_req` and `bus_cyc` are low.
- R6: After a transfer error the channel starts no bus cycle and ignores `start` until `reinit` is pulsed. After that, a new start runs normally.
- R7: An operand held internally when an error hits is discarded and never written. A transfer restarted after `reinit` writes freshly read data only.
- R8: In single-address mode (`cfg_single`=1), operand i is one cycle at `cfg_src`+i with `bus_we` low and `hs_ack` high. `bus_err` drops `hs_ack` in the same cycle.
- R9: `irq` is registered. It is high one cycle after any `sts` bit whose matching `msk_wdata` bit is set (bit 1 error, bit 0 done, written with `msk_we`). Masked bits never raise it.
- R10: A 1 in `sts_w1c` clears the matching `sts` bit at the next edge. Status bits otherwise stay set.
- R11: A start with count 0 is ignored, and the channel stays idle without requesting the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset; aborts at once |
| start | input | 1 | Start strobe, accepted only when idle |
| cfg_src | input | AW | First source address |
| cfg_dst | input | AW | First destination address |
| cfg_cnt | input | CW | Number of operands |
| cfg_single | input | 1 | 1 selects single-address handshake mode |
| reinit | input | 1 | Controller strobe that leaves the error-halt state |
| sts_w1c | input | 2 | Write-one-to-clear strobes for the status bits |
| msk_we | input | 1 | Mask register write enable |
| msk_wdata | input | 2 | Mask value (bit 1 error, bit 0 done) |
| sts | output | 2 | Status: bit 1 error, bit 0 done |
| irq | output | 1 | Registered interrupt |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_cyc | output | 1 | Cycle strobe; when low, address, data and control drivers are in high impedance |
| bus_we | output | 1 | Write cycle indicator |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Normal cycle completion |
| bus_err | input | 1 | Transfer error |
| hs_ack | output | 1 | Peripheral acknowledge for single-address cycles |

## Verification
The transfer path is exercised with dual-address and single-address runs of several lengths and with the grant held back for a few cycles. These runs separate correct address stepping and data forwarding from a channel that starts a cycle before ownership. Errors are injected on a read, on a write together with an acknowledge, and on a single-address cycle. Those three cases separate loss of the held operand, error priority and the same-cycle acknowledge drop. Mask settings and a reset during a stretched cycle separate the interrupt gating from the immediate release of the bus.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_RD,
        ST_WR,
        ST_SA,
        ST_HALT
    } chan_st_e;

    typedef struct packed {
        logic err;
        logic done;
    } chan_sts_t;

    localparam int STS_W = $bits(chan_sts_t);

    function automatic logic st_in_cycle(chan_st_e s);
        return (s == ST_RD) || (s == ST_WR) || (s == ST_SA);
    endfunction

    function automatic logic st_wants_bus(chan_st_e s);
        return (s == ST_ARB) || st_in_cycle(s);
    endfunction

endpackage

// File: rtl/dma_err_fsm.sv
module dma_err_fsm
    import dma_err_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic          cfg_single,
    input  logic          reinit,
    input  logic          bus_grant,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata,
    output chan_st_e      st,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [DW-1:0] hold_q,
    output logic          done_evt,
    output logic          err_evt
);

    logic [CW-1:0] left_q;
    logic          single_q;
    logic          in_cyc;
    logic          ack_hit;
    logic          last_op;

    assign in_cyc   = st_in_cycle(st);
    assign err_evt  = in_cyc && bus_err;
    assign ack_hit  = in_cyc && bus_ack && !bus_err;
    assign last_op  = (left_q == CW'(1));
    assign done_evt = ack_hit && last_op && ((st == ST_WR) || (st == ST_SA));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_src  <= '0;
            cur_dst  <= '0;
            left_q   <= '0;
            single_q <= 1'b0;
            hold_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start && (cfg_cnt != '0)) begin
                        cur_src  <= cfg_src;
                        cur_dst  <= cfg_dst;
                        left_q   <= cfg_cnt;
                        single_q <= cfg_single;
                        st       <= ST_ARB;
                    end
                end
                ST_ARB: begin
                    if (bus_grant) begin
                        st <= single_q ? ST_SA : ST_RD;
                    end
                end
                ST_RD: begin
                    if (err_evt) begin
                        hold_q <= '0;
                        st     <= ST_HALT;
                    end else if (ack_hit) begin
                        hold_q <= bus_rdata;
                        st     <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (err_evt) begin
                        hold_q <= '0;
                        st     <= ST_HALT;
                    end else if (ack_hit) begin
                        hold_q  <= '0;
                        cur_src <= cur_src + AW'(1);
                        cur_dst <= cur_dst + AW'(1);
                        left_q  <= left_q - CW'(1);
                        st      <= last_op ? ST_IDLE : ST_ARB;
                    end
                end
                ST_SA: begin
                    if (err_evt) begin
                        st <= ST_HALT;
                    end else if (ack_hit) begin
                        cur_src <= cur_src + AW'(1);
                        left_q  <= left_q - CW'(1);
                        st      <= last_op ? ST_IDLE : ST_ARB;
                    end
                end
                ST_HALT: begin
                    if (reinit) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (st == ST_IDLE)) else $error("reset did not idle"); // R1

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALT) && !reinit |=> (st == ST_HALT)) else $error("halt left without reinit"); // R6

endmodule

// File: rtl/dma_err_bus.sv
module dma_err_bus
    import dma_err_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_st_e      st,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  logic [DW-1:0] hold_q,
    input  logic          bus_err,
    output logic          bus_req,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          hs_ack
);

    logic live;
    logic wr_cyc;

    assign live    = !rst;
    assign bus_req = live && st_wants_bus(st);
    assign bus_cyc = live && st_in_cycle(st);
    assign wr_cyc  = bus_cyc && (st == ST_WR);
    assign bus_we  = wr_cyc;

    always_comb begin
        bus_addr = '0;
        if (bus_cyc) begin
            bus_addr = wr_cyc ? cur_dst : cur_src;
        end
    end

    assign bus_wdata = wr_cyc ? hold_q : '0;
    assign hs_ack    = bus_cyc && (st == ST_SA) && !bus_err;

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_err) |=> (!bus_req && !bus_cyc)) else $error("request kept after error"); // R5

endmodule

// File: rtl/dma_err_regs.sv
module dma_err_regs
    import dma_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done_evt,
    input  logic             err_evt,
    input  logic [STS_W-1:0] sts_w1c,
    input  logic             msk_we,
    input  logic [STS_W-1:0] msk_wdata,
    output logic [STS_W-1:0] sts,
    output logic             irq
);

    chan_sts_t sts_q;
    chan_sts_t msk_q;
    chan_sts_t set_v;

    always_comb begin
        set_v.err  = err_evt;
        set_v.done = done_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            msk_q <= '0;
            irq   <= 1'b0;
        end else begin
            sts_q <= (sts_q & ~chan_sts_t'(sts_w1c)) | set_v;
            if (msk_we) begin
                msk_q <= chan_sts_t'(msk_wdata);
            end
            irq <= |(sts_q & msk_q);
        end
    end

    assign sts = sts_q;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (msk_q == '0) |=> !irq) else $error("irq with all masked"); // R9

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
        sts_q.err && !sts_w1c[1] |=> sts_q.err) else $error("error bit lost"); // R10

endmodule

// File: rtl/dma_err_chan.sv
module dma_err_chan
    import dma_err_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic          cfg_single,
    input  logic          reinit,
    input  logic [1:0]    sts_w1c,
    input  logic          msk_we,
    input  logic [1:0]    msk_wdata,
    output logic [1:0]    sts,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          hs_ack
);

    chan_st_e      st;
    logic [AW-1:0] cur_src;
    logic [AW-1:0] cur_dst;
    logic [DW-1:0] hold_q;
    logic          done_evt;
    logic          err_evt;

    dma_err_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_src    (cfg_src),
        .cfg_dst    (cfg_dst),
        .cfg_cnt    (cfg_cnt),
        .cfg_single (cfg_single),
        .reinit     (reinit),
        .bus_grant  (bus_grant),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .st         (st),
        .cur_src    (cur_src),
        .cur_dst    (cur_dst),
        .hold_q     (hold_q),
        .done_evt   (done_evt),
        .err_evt    (err_evt)
    );

    dma_err_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst),
        .hold_q    (hold_q),
        .bus_err   (bus_err),
        .bus_req   (bus_req),
        .bus_cyc   (bus_cyc),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hs_ack    (hs_ack)
    );

    dma_err_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .sts_w1c   (sts_w1c),
        .msk_we    (msk_we),
        .msk_wdata (msk_wdata),
        .sts       (sts),
        .irq       (irq)
    );

    AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cyc) |-> $past(bus_grant)) else $error("cycle without grant"); // R3

    AST_ERR_STATUS: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_err) |=> sts[1]) else $error("error not recorded"); // R4

endmodule

// File: tb/dma_err_chan_bench.sv
module dma_err_chan_bench;

    typedef struct {
        logic [15:0] addr;
        logic        we;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] cfg_src = '0;
    logic [15:0] cfg_dst = '0;
    logic [7:0]  cfg_cnt = '0;
    logic        cfg_single = 1'b0;
    logic        reinit = 1'b0;
    logic [1:0]  sts_w1c = '0;
    logic        msk_we = 1'b0;
    logic [1:0]  msk_wdata = '0;
    logic [1:0]  sts;
    logic        irq;
    logic        bus_req;
    logic        bus_grant;
    logic        bus_cyc;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic        hs_ack;

    logic        gnt_en = 1'b1;
    int          checks = 0;
    int          errors = 0;
    int          cyc_idx = 0;
    int          err_idx = 0;
    logic        err_with_ack = 1'b0;
    logic        single_mode = 1'b0;
    int          wait_states = 0;
    int          wait_cnt = 0;
    int          clk_count = 0;
    exp_t        exp_q[$];

    assign bus_grant = bus_req && gnt_en;

    always #2.5 clk = ~clk;

    dma_err_chan u_dma_err_chan (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_src    (cfg_src),
        .cfg_dst    (cfg_dst),
        .cfg_cnt    (cfg_cnt),
        .cfg_single (cfg_single),
        .reinit     (reinit),
        .sts_w1c    (sts_w1c),
        .msk_we     (msk_we),
        .msk_wdata  (msk_wdata),
        .sts        (sts),
        .irq        (irq),
        .bus_req    (bus_req),
        .bus_grant  (bus_grant),
        .bus_cyc    (bus_cyc),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .hs_ack     (hs_ack)
    );

    function automatic logic [15:0] pat(logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        clk_count++;
        if (clk_count > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", clk_count);
            finish_sim();
        end
    end

    // monitor and bus responder: pops expected cycles and compares
    always @(negedge clk) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (rst || !bus_cyc) begin
            wait_cnt = 0;
        end else if (wait_cnt < wait_states) begin
            wait_cnt++;
        end else begin
            wait_cnt = 0;
            cyc_idx++;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6/R7 unexpected cycle: actual addr %0h expected none", bus_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " addr"}, 32'(bus_addr), 32'(e.addr));
                chk({e.tag, " we"}, 32'(bus_we), 32'(e.we));
                if (e.we) chk({e.tag, " wdata"}, 32'(bus_wdata), 32'(e.data));
                if (single_mode) chk("R8 hs_ack high in cycle", 32'(hs_ack), 32'd1);
            end
            bus_rdata = pat(bus_addr);
            if (cyc_idx == err_idx) begin
                bus_err = 1'b1;
                bus_ack = err_with_ack;
                if (single_mode) begin
                    #1 chk("R8 hs_ack drops with error", 32'(hs_ack), 32'd0);
                end
            end else begin
                bus_ack = 1'b1;
            end
        end
    end

    task automatic run_xfer(input logic [15:0] src, input logic [15:0] dst, input int n,
                            input logic single, input int eidx, input logic ewack);
        int total;
        int lim;
        err_idx      = eidx;
        err_with_ack = ewack;
        cyc_idx      = 0;
        single_mode  = single;
        total = single ? n : 2 * n;
        lim   = (eidx != 0) ? eidx : total;
        for (int k = 1; k <= lim; k++) begin
            exp_t e;
            if (single) begin
                e.addr = src + 16'(k - 1);
                e.we   = 1'b0;
                e.data = '0;
                e.tag  = "R8 single cycle";
            end else if (k % 2 == 1) begin
                e.addr = src + 16'((k - 1) / 2);
                e.we   = 1'b0;
                e.data = '0;
                e.tag  = "R2 read";
            end else begin
                e.addr = dst + 16'((k - 1) / 2);
                e.we   = 1'b1;
                e.data = pat(src + 16'((k - 1) / 2));
                e.tag  = "R2 write";
            end
            exp_q.push_back(e);
        end
        cfg_src    = src;
        cfg_dst    = dst;
        cfg_cnt    = 8'(n);
        cfg_single = single;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_sts();
        int t = 0;
        while (sts == 2'b00 && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse_clear(input logic [1:0] v);
        sts_w1c = v;
        @(negedge clk);
        sts_w1c = 2'b00;
    endtask

    task automatic set_mask(input logic [1:0] v);
        msk_wdata = v;
        msk_we    = 1'b1;
        @(negedge clk);
        msk_we    = 1'b0;
    endtask

    task automatic pulse_reinit();
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
    endtask

    initial begin
        // R1 reset state
        @(negedge clk);
        chk("R1 req low in reset", 32'(bus_req), 0);
        chk("R1 cyc low in reset", 32'(bus_cyc), 0);
        chk("R1 hs_ack low in reset", 32'(hs_ack), 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status after reset", 32'(sts), 0);
        chk("R1 irq after reset", 32'(irq), 0);

        // R2 dual transfer, done interrupt enabled
        set_mask(2'b01);
        run_xfer(16'h0100, 16'h0200, 3, 1'b0, 0, 1'b0);
        wait_sts();
        chk("R2 done status", 32'(sts), 32'b01);
        chk("R2 all cycles seen", 32'(exp_q.size()), 0);
        @(negedge clk);
        chk("R9 irq on unmasked done", 32'(irq), 1);
        pulse_clear(2'b01);
        chk("R10 done cleared", 32'(sts), 0);
        @(negedge clk);
        chk("R9 irq falls after clear", 32'(irq), 0);

        // R3 grant withheld
        gnt_en = 1'b0;
        run_xfer(16'h0300, 16'h0400, 2, 1'b0, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R3 request held", 32'(bus_req), 1);
        chk("R3 no cycle without grant", 32'(bus_cyc), 0);
        gnt_en = 1'b1;
        wait_sts();
        chk("R3 done after grant", 32'(sts), 32'b01);
        chk("R3 request released when idle", 32'(bus_req), 0);
        chk("R2 queue drained", 32'(exp_q.size()), 0);
        pulse_clear(2'b11);

        // R8 single-address transfer
        run_xfer(16'h0800, 16'h0000, 3, 1'b1, 0, 1'b0);
        wait_sts();
        chk("R8 single done", 32'(sts), 32'b01);
        chk("R8 queue drained", 32'(exp_q.size()), 0);
        pulse_clear(2'b11);

        // R11 zero count
        cfg_cnt = 8'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 no request for zero count", 32'(bus_req), 0);
        chk("R11 no status for zero count", 32'(sts), 0);

        // R4/R5/R6 error on a read cycle
        set_mask(2'b10);
        run_xfer(16'h0500, 16'h0600, 4, 1'b0, 3, 1'b0);
        wait_sts();
        chk("R4 error status", 32'(sts), 32'b10);
        chk("R5 request dropped", 32'(bus_req), 0);
        chk("R5 cycle ended", 32'(bus_cyc), 0);
        @(negedge clk);
        chk("R9 irq on unmasked error", 32'(irq), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 start ignored while halted", 32'(bus_req), 0);
        chk("R7 no write of lost operand", 32'(exp_q.size()), 0);
        pulse_reinit();
        pulse_clear(2'b11);
        run_xfer(16'h0A00, 16'h0B00, 2, 1'b0, 0, 1'b0);
        wait_sts();
        chk("R6 restart after reinit", 32'(sts), 32'b01);
        chk("R6 queue drained", 32'(exp_q.size()), 0);
        pulse_clear(2'b11);

        // R4/R7 error on a write together with ack
        run_xfer(16'h0C00, 16'h0D00, 3, 1'b0, 2, 1'b1);
        wait_sts();
        chk("R4 error wins over ack", 32'(sts), 32'b10);
        repeat (10) @(negedge clk);
        chk("R7 no further cycles", 32'(exp_q.size()), 0);
        pulse_reinit();
        pulse_clear(2'b11);
        run_xfer(16'h0C00, 16'h0E00, 1, 1'b0, 0, 1'b0);
        wait_sts();
        chk("R7 fresh data after reinit", 32'(sts), 32'b01);
        chk("R7 queue drained", 32'(exp_q.size()), 0);
        pulse_clear(2'b11);

        // R8/R9 single-address error with all masked
        set_mask(2'b00);
        run_xfer(16'h0F00, 16'h0000, 3, 1'b1, 2, 1'b0);
        wait_sts();
        chk("R4 single error status", 32'(sts), 32'b10);
        @(negedge clk);
        chk("R9 masked error no irq", 32'(irq), 0);
        pulse_reinit();

        // R1 reset during a stretched cycle, error bit still set
        set_mask(2'b10);
        wait_states = 4;
        run_xfer(16'h1000, 16'h1100, 2, 1'b0, 0, 1'b0);
        while (!bus_cyc) @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R1 cycle released at once", 32'(bus_cyc), 0);
        chk("R1 request released at once", 32'(bus_req), 0);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        wait_states = 0;
        @(negedge clk);
        chk("R1 status cleared by reset", 32'(sts), 0);
        chk("R1 irq cleared by reset", 32'(irq), 0);
        chk("R1 idle after reset", 32'(bus_req), 0);
        run_xfer(16'h1200, 16'h1300, 1, 1'b0, 0, 1'b0);
        wait_sts();
        chk("R2 transfer after reset", 32'(sts), 32'b01);
        chk("R2 queue drained", 32'(exp_q.size()), 0);

        repeat (3) @(negedge clk);
        finish_sim();
    end

endmodule